// File: doc/BRIEF.md
# MSI Vector Dispatcher

The dispatcher sits between the interrupt sources of a PCI-style function and its bus-master port. Device logic raises a request for a numbered vector; the block checks that message interrupts are enabled and that the vector lies inside the enabled vector count. It then either turns the request into one 32-bit memory write on a request/acknowledge port, or, when per-vector masking is built in and the vector's mask bit is set, parks it by pulsing that vector's bit on a pending-set strobe. The capability register file owns all storage. The block reads the enable bit, the requested vector-count field, the address, the data, the mask and the pending word from it, and sends pending-set and pending-clear strobes back. Those strobes take effect at the next clock edge.

The write address is the programmed low word, with the programmed high word above it when the 64-bit variant is built. The write data is the programmed 16-bit value, zero-extended to 32 bits, with its low bits replaced by the vector number. When the register file signals a configuration write while messages are enabled, the block clears pending bits that now lie outside the enabled range. It then replays every unmasked pending vector, lowest number first, one write at a time. Fresh device requests always go ahead of replays. While messages are enabled, the legacy level interrupt is held off.

Top module: `msi_dispatch`

## Requirements
- R1: Write data is `{16'h0000, cfg_data}` with bits [k-1:0] replaced by the vector number, where k is the effective log2 vector count. With k = 0 the data goes out unchanged.
- R2: With the 64-bit variant (default) the write address is `{cfg_addr_hi, cfg_addr_lo}`. Otherwise the upper 32 bits are zero.
- R3: An accepted, valid request whose vector has its `cfg_mask` bit set issues no write. Instead, one cycle after acceptance, `pend_set` pulses for one cycle with only that vector's bit (bit i = vector i) high.
- R4: On a `cfg_wr` pulse while `cfg_enable` is 1, `pend_clr` pulses in the next cycle for every `cfg_pend` bit at or above the enabled vector count 2^k.
- R5: After such a `cfg_wr`, every pending vector inside the range with its mask bit clear is written out in ascending vector order. Each gets one `pend_clr` pulse on its bit. Masked pending vectors remain pending.
- R6: `intx_out` is 0 while `cfg_enable` is 1 and equals `intx_req` while it is 0.
- R7: A request accepted with `cfg_enable` at 0, or with a vector at or above 2^k, pulses `err` for one cycle one cycle after acceptance. It causes no write and no pending change.
- R8: Only one write is outstanding. `mw_valid` stays high with stable `mw_addr` and `mw_data` until the cycle in which `mw_ack` is high, and `req_ready` is 0 while `mw_valid` is 1.
- R9: When the port frees up while both a device request and a replay candidate are waiting, the device request is written first.
- R10: A `cfg_log_req` value above log2(CAP_VEC) = 5 is treated as 5 for both the range check and the data substitution.
- R11: After reset `mw_valid`, `err`, `pend_set` and `pend_clr` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Message interrupts enabled |
| cfg_log_req | input | 3 | Requested log2 of enabled vector count |
| cfg_addr_lo | input | 32 | Programmed address, low word |
| cfg_addr_hi | input | 32 | Programmed address, high word |
| cfg_data | input | 16 | Programmed message data |
| cfg_mask | input | CAP_VEC | Per-vector mask bits |
| cfg_pend | input | CAP_VEC | Per-vector pending bits |
| cfg_wr | input | 1 | One-cycle pulse after any configuration write |
| req_valid | input | 1 | Device interrupt request |
| req_vec | input | log2(CAP_VEC) | Requested vector number |
| req_ready | output | 1 | Request accepted this cycle when high |
| mw_valid | output | 1 | Memory-write request |
| mw_addr | output | 64 | Write address |
| mw_data | output | 32 | Write data (one little-endian dword) |
| mw_ack | input | 1 | Write accepted |
| pend_set | output | CAP_VEC | Pending-bit set strobes |
| pend_clr | output | CAP_VEC | Pending-bit clear strobes |
| err | output | 1 | Dropped-request pulse |
| intx_req | input | 1 | Legacy level interrupt from device |
| intx_out | output | 1 | Legacy level interrupt after gating |

## Verification
The case hardest to reach from the ports is a device request that arrives while a replay sequence is stalled behind a slow acknowledge. Only that timing shows the arbitration between the two sources. The bench gets there by loading two pending bits through the register-file model and stretching the acknowledge latency to several cycles. It issues the configuration-write pulse, waits for the first replay write to appear, and then raises a device request, so that the free port is contested. Random phases build up pending state from masked requests under changing vector counts and data, and finish with an unmasking configuration write whose ascending replay is checked against the bench's record.

// File: rtl/msi_pkg.sv
// Shared widths and the message type for the message interrupt dispatcher.
package msi_pkg;
    localparam int LOG_FIELD_W = 3;
    localparam int ADDR_W      = 64;
    localparam int DATA_W      = 32;
    localparam int PROG_DATA_W = 16;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } msi_msg_t;
endpackage

// File: rtl/msi_msg_build.sv
// Composes the address and data of one message write.
// Assumes log_eff has already been clamped to at most VW.
module msi_msg_build #(
    parameter int VW     = 5,
    parameter bit ADDR64 = 1'b1
) (
    input  logic [msi_pkg::LOG_FIELD_W-1:0] log_eff,
    input  logic [VW-1:0]                   vec,
    input  logic [31:0]                     addr_lo,
    input  logic [31:0]                     addr_hi,
    input  logic [msi_pkg::PROG_DATA_W-1:0] data,
    output msi_pkg::msi_msg_t               msg
);
    logic [msi_pkg::PROG_DATA_W-1:0] mixed;

    // Per data bit: take the vector bit when inside the substituted field.
    for (genvar i = 0; i < msi_pkg::PROG_DATA_W; i++) begin : g_bit
        if (i < VW) begin : g_sub
            assign mixed[i] = (int'(log_eff) > i) ? vec[i] : data[i];
        end else begin : g_keep
            assign mixed[i] = data[i];
        end
    end

    // Address variant chosen by parameter.
    if (ADDR64) begin : g_a64
        assign msg.addr = {addr_hi, addr_lo};
    end else begin : g_a32
        assign msg.addr = {32'h0, addr_lo};
    end

    assign msg.data = {{(msi_pkg::DATA_W-msi_pkg::PROG_DATA_W){1'b0}}, mixed};
endmodule

// File: rtl/msi_first_set.sv
// Finds the lowest set bit of a vector; found is low when the vector is zero.
module msi_first_set #(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Downward scan so that the lowest set bit is the last one written.
    always_comb begin
        found = |bits;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/msi_dispatch.sv
// Message interrupt dispatcher: accepts device vector requests, emits message
// writes, parks masked vectors as pending and replays them after a
// configuration write. Assumes CAP_VEC is a power of two from 2 to 64 and that
// the register file applies pend_set/pend_clr at the following clock edge.
module msi_dispatch #(
    parameter int CAP_VEC  = 32,
    parameter bit HAS_MASK = 1'b1,
    parameter bit ADDR64   = 1'b1,
    localparam int VW = $clog2(CAP_VEC),
    localparam int LW = msi_pkg::LOG_FIELD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_enable,
    input  logic [LW-1:0]           cfg_log_req,
    input  logic [31:0]             cfg_addr_lo,
    input  logic [31:0]             cfg_addr_hi,
    input  logic [15:0]             cfg_data,
    input  logic [CAP_VEC-1:0]      cfg_mask,
    input  logic [CAP_VEC-1:0]      cfg_pend,
    input  logic                    cfg_wr,
    input  logic                    req_valid,
    input  logic [VW-1:0]           req_vec,
    output logic                    req_ready,
    output logic                    mw_valid,
    output logic [63:0]             mw_addr,
    output logic [31:0]             mw_data,
    input  logic                    mw_ack,
    output logic [CAP_VEC-1:0]      pend_set,
    output logic [CAP_VEC-1:0]      pend_clr,
    output logic                    err,
    input  logic                    intx_req,
    output logic                    intx_out
);
    import msi_pkg::*;

    logic [LW-1:0]      log_eff;
    logic [VW:0]        vec_cnt;
    logic [CAP_VEC-1:0] in_range;
    logic [CAP_VEC-1:0] cand;
    logic               cand_found;
    logic [VW-1:0]      cand_idx;
    logic               req_fire, req_ok, req_masked, req_send, scan_go;
    logic               cfg_hit;
    logic               replay_q;
    logic [VW-1:0]      sel_vec;
    msi_msg_t           msg;

    // Clamp the requested vector-count field to the built capacity.
    assign log_eff = (cfg_log_req > LW'(VW)) ? LW'(VW) : cfg_log_req;
    assign vec_cnt = (VW+1)'(1) << log_eff;

    // Per-vector range flag against the enabled count.
    for (genvar i = 0; i < CAP_VEC; i++) begin : g_rng
        assign in_range[i] = (VW+1)'(i) < vec_cnt;
    end

    // Replay candidates exist only when masking is built in.
    if (HAS_MASK) begin : g_mask
        assign cand       = cfg_pend & ~cfg_mask & in_range;
        assign req_masked = cfg_mask[req_vec];
    end else begin : g_nomask
        assign cand       = '0;
        assign req_masked = 1'b0;
    end

    msi_first_set #(.N(CAP_VEC)) u_first (
        .bits  (cand),
        .found (cand_found),
        .idx   (cand_idx)
    );

    // Acceptance and arbitration: device request beats replay.
    assign req_ready = !mw_valid;
    assign req_fire  = req_valid && req_ready;
    assign req_ok    = cfg_enable && in_range[req_vec];
    assign req_send  = req_fire && req_ok && !req_masked;
    assign scan_go   = replay_q && cfg_enable && !mw_valid && !req_fire && cand_found;
    assign cfg_hit   = cfg_wr && cfg_enable && HAS_MASK;
    assign sel_vec   = req_fire ? req_vec : cand_idx;

    msi_msg_build #(.VW(VW), .ADDR64(ADDR64)) u_build (
        .log_eff (log_eff),
        .vec     (sel_vec),
        .addr_lo (cfg_addr_lo),
        .addr_hi (cfg_addr_hi),
        .data    (cfg_data),
        .msg     (msg)
    );

    // Legacy interrupt is held off while messages are enabled.
    assign intx_out = intx_req && !cfg_enable;

    // Strobe outputs: error, pending set, pending clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err      <= 1'b0;
            pend_set <= '0;
            pend_clr <= '0;
        end else begin
            err      <= req_fire && !req_ok;
            pend_set <= (req_fire && req_ok && req_masked) ? (CAP_VEC'(1) << req_vec) : '0;
            pend_clr <= (cfg_hit ? (cfg_pend & ~in_range) : '0)
                      | (scan_go ? (CAP_VEC'(1) << cand_idx) : '0);
        end
    end

    // Replay sequence flag: armed by a config write, dropped when nothing is left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            replay_q <= 1'b0;
        end else if (cfg_hit) begin
            replay_q <= 1'b1;
        end else if (!cfg_enable || (replay_q && !mw_valid && !req_fire && !cand_found)) begin
            replay_q <= 1'b0;
        end
    end

    // Single outstanding write with a held payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mw_valid <= 1'b0;
            mw_addr  <= '0;
            mw_data  <= '0;
        end else if (mw_valid && mw_ack) begin
            mw_valid <= 1'b0;
        end else if (!mw_valid && (req_send || scan_go)) begin
            mw_valid <= 1'b1;
            mw_addr  <= msg.addr;
            mw_data  <= msg.data;
        end
    end
endmodule

// File: rtl/msi_dispatch_chk.sv
// Protocol checks for the dispatcher, attached by bind.
module msi_dispatch_chk #(
    parameter int CAP_VEC = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CAP_VEC-1:0] cfg_mask,
    input logic               mw_valid,
    input logic [63:0]        mw_addr,
    input logic [31:0]        mw_data,
    input logic               mw_ack,
    input logic [CAP_VEC-1:0] pend_set,
    input logic               err
);
    // R8: payload held until acknowledged
    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_valid && !mw_ack) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

    // R3: at most one pending bit set per cycle
    a_r3_set_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_set));

    // R3: pending only for a vector that was masked at acceptance
    a_r3_set_only_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_set != '0) |-> ((pend_set & ~$past(cfg_mask)) == '0));

    // R1: upper half of a new write is zero
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mw_valid) |-> (mw_data[31:16] == 16'h0));

    // R7: a dropped request never starts a write
    a_r7_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !$rose(mw_valid));
endmodule

bind msi_dispatch msi_dispatch_chk #(.CAP_VEC(CAP_VEC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mask (cfg_mask),
    .mw_valid (mw_valid),
    .mw_addr  (mw_addr),
    .mw_data  (mw_data),
    .mw_ack   (mw_ack),
    .pend_set (pend_set),
    .err      (err)
);

// File: tb/tb_msi_dispatch.sv
module tb_msi_dispatch;
    localparam int NV = 32;
    localparam int VW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b0;
    logic [2:0] cfg_log_req = '0;
    logic [31:0] cfg_addr_lo = '0, cfg_addr_hi = '0;
    logic [15:0] cfg_data = '0;
    logic [NV-1:0] cfg_mask = '0, cfg_pend = '0;
    logic cfg_wr = 1'b0;
    logic req_valid = 1'b0;
    logic [VW-1:0] req_vec = '0;
    logic req_ready, mw_valid, mw_ack = 1'b0;
    logic [63:0] mw_addr;
    logic [31:0] mw_data;
    logic [NV-1:0] pend_set, pend_clr;
    logic err, intx_req = 1'b0, intx_out;

    int n_chk = 0, n_fail = 0;
    int ack_lat = 0, ack_cnt = 0;
    logic poke_en = 1'b0;
    logic [NV-1:0] poke_val = '0;
    int err_seen = 0;
    logic [63:0] got_a [0:1023];
    logic [31:0] got_d [0:1023];
    logic [63:0] exp_a [0:1023];
    logic [31:0] exp_d [0:1023];
    int n_got = 0, n_exp = 0, cmp_ptr = 0;

    always #10 clk = ~clk;

    msi_dispatch dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_log_req(cfg_log_req),
        .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi), .cfg_data(cfg_data),
        .cfg_mask(cfg_mask), .cfg_pend(cfg_pend), .cfg_wr(cfg_wr),
        .req_valid(req_valid), .req_vec(req_vec), .req_ready(req_ready),
        .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data), .mw_ack(mw_ack),
        .pend_set(pend_set), .pend_clr(pend_clr), .err(err),
        .intx_req(intx_req), .intx_out(intx_out)
    );

    // Register-file model and write/error monitor.
    initial forever begin
        @(posedge clk);
        if (mw_valid && mw_ack && n_got < 1024) begin
            got_a[n_got] = mw_addr;
            got_d[n_got] = mw_data;
            n_got++;
        end
        if (err) err_seen++;
        cfg_pend <= poke_en ? poke_val : ((cfg_pend | pend_set) & ~pend_clr);
    end

    // Acknowledge responder with programmable latency.
    initial forever begin
        @(negedge clk);
        if (!mw_valid) begin
            mw_ack = 1'b0; ack_cnt = 0;
        end else if (mw_ack) begin
            ack_cnt = 0; mw_ack = (ack_lat == 0);
        end else if (ack_cnt >= ack_lat) begin
            mw_ack = 1'b1;
        end else begin
            ack_cnt++;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, expv);
        end
    endtask

    function automatic logic [31:0] f_data(input int vec, input logic [15:0] d, input logic [2:0] lg);
        int k = (lg > 3'd5) ? 5 : int'(lg);
        logic [15:0] r = d;
        for (int i = 0; i < k; i++) r[i] = vec[i];
        return {16'h0, r};
    endfunction

    task automatic push_exp(input int vec);
        exp_a[n_exp] = {cfg_addr_hi, cfg_addr_lo};
        exp_d[n_exp] = f_data(vec, cfg_data, cfg_log_req);
        n_exp++;
    endtask

    task automatic send_req(input int vec);
        @(negedge clk);
        req_valid = 1'b1; req_vec = VW'(vec);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_cfg();
        @(negedge clk); cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic poke(input logic [NV-1:0] v);
        @(negedge clk); poke_en = 1'b1; poke_val = v;
        @(negedge clk); poke_en = 1'b0;
    endtask

    task automatic wait_idle();
        int idle = 0;
        for (int t = 0; t < 400 && idle < 4; t++) begin
            @(negedge clk);
            if (mw_valid) idle = 0; else idle++;
        end
    endtask

    task automatic cmp_writes(input string rq);
        wait_idle();
        chk(n_got == n_exp, {rq, " write count"}, 64'(n_got), 64'(n_exp));
        for (int i = cmp_ptr; i < n_got && i < n_exp; i++) begin
            chk(got_a[i] == exp_a[i], {rq, " addr"}, got_a[i], exp_a[i]);
            chk(got_d[i] == exp_d[i], {rq, " data"}, 64'(got_d[i]), 64'(exp_d[i]));
        end
        cmp_ptr = n_got;
        n_exp = n_got;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [NV-1:0] exp_pend;
        int e0;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!mw_valid && !err, "R11 idle", {62'h0, mw_valid, err}, 64'h0);
        chk(pend_set == '0 && pend_clr == '0, "R11 strobes", 64'(pend_set | pend_clr), 64'h0);
        chk(req_ready, "R11 ready", 64'(req_ready), 64'h1);

        // R1 R2 substitution and address
        cfg_enable = 1'b1; cfg_log_req = 3'd2; cfg_data = 16'h1235;
        cfg_addr_lo = 32'hFEE0_1000; cfg_addr_hi = 32'h0000_00A5;
        push_exp(2); send_req(2);
        cfg_log_req = 3'd0; @(negedge clk);
        push_exp(0); send_req(0);
        cmp_writes("R1 R2");
        chk(exp_d[0] == 32'h0000_1236, "R1 field value", 64'(exp_d[0]), 64'h1236);

        // R6 legacy gating
        intx_req = 1'b1; @(negedge clk);
        chk(intx_out == 1'b0, "R6 enabled", 64'(intx_out), 64'h0);
        cfg_enable = 1'b0; @(negedge clk);
        chk(intx_out == 1'b1, "R6 disabled", 64'(intx_out), 64'h1);
        intx_req = 1'b0;

        // R7 dropped requests
        e0 = err_seen;
        send_req(0);
        cfg_enable = 1'b1; cfg_log_req = 3'd1;
        send_req(3);
        repeat (3) @(negedge clk);
        chk(err_seen == e0 + 2, "R7 err pulses", 64'(err_seen - e0), 64'h2);
        chk(cfg_pend == '0, "R7 no pending", 64'(cfg_pend), 64'h0);
        cmp_writes("R7");

        // R10 clamp of the count field
        cfg_log_req = 3'd7; cfg_data = 16'hFF00;
        push_exp(31); send_req(31);
        cmp_writes("R10");
        chk(exp_d[n_exp-1] == 32'h0000_FF1F, "R10 field value", 64'(exp_d[n_exp-1]), 64'hFF1F);

        // R3 masked request parks
        cfg_log_req = 3'd3; cfg_mask = NV'(32'h20);
        send_req(5);
        repeat (3) @(negedge clk);
        chk(cfg_pend == NV'(32'h20), "R3 pending bit", 64'(cfg_pend), 64'h20);
        cmp_writes("R3");

        // R4 R5 discard and ascending replay
        cfg_mask = NV'(32'h4);
        poke(NV'(32'h8000_0026));
        push_exp(1); push_exp(5);
        pulse_cfg();
        cmp_writes("R5 order");
        chk(cfg_pend == NV'(32'h4), "R4 R5 final pending", 64'(cfg_pend), 64'h4);

        // R9 R8 device request beats replay under slow acknowledge
        ack_lat = 6; cfg_mask = '0;
        poke(NV'(32'hA));
        pulse_cfg();
        while (!mw_valid) @(negedge clk);
        @(negedge clk);
        chk(!req_ready, "R8 ready low while busy", 64'(req_ready), 64'h0);
        push_exp(1); push_exp(6); push_exp(3);
        send_req(6);
        cmp_writes("R9 order");
        chk(cfg_pend == '0, "R5 all replayed", 64'(cfg_pend), 64'h0);

        // Random phase: masked and unmasked requests, then one unmasking replay
        exp_pend = '0;
        for (int it = 0; it < 300; it++) begin
            int v;
            ack_lat = $urandom_range(0, 3);
            cfg_log_req = 3'($urandom_range(0, 5));
            cfg_mask = NV'($urandom);
            cfg_data = 16'($urandom);
            cfg_addr_lo = $urandom & 32'hFFFF_FFFC;
            cfg_addr_hi = $urandom;
            v = int'($urandom % (32'd1 << cfg_log_req));
            if (cfg_mask[v]) exp_pend[v] = 1'b1;
            else push_exp(v);
            send_req(v);
        end
        repeat (4) @(negedge clk);
        chk(cfg_pend == exp_pend, "R3 random pending", 64'(cfg_pend), 64'(exp_pend));
        cmp_writes("R1 R2 random");
        cfg_mask = '0; cfg_log_req = 3'd5;
        @(negedge clk);
        for (int b = 0; b < NV; b++) if (exp_pend[b]) push_exp(b);
        pulse_cfg();
        cmp_writes("R5 random replay");
        chk(cfg_pend == '0, "R5 random drained", 64'(cfg_pend), 64'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule